// File: doc/BRIEF.md
# Inter-Processor Condition Handshake Register

This block passes one-bit condition results between a single-cycle bit processor and a byte processor that run on the same clock but follow their own programs. It holds two one-bit mailboxes, one for each direction. The bit-to-byte mailbox is loaded by a transfer strobe on the bit side and is emptied by a fetch strobe on the byte side. The byte-to-bit mailbox is loaded by a post strobe on the byte side and is emptied by a probe strobe on the bit side.

Each mailbox has a full/vacant status pair. A processor that tries to take from a vacant mailbox, or tries to load a mailbox whose value has not been taken yet, receives a stall. That processor keeps its strobe asserted while the stall is high. The stalls are combinational from the strobes and the status. A held strobe therefore completes in the first cycle in which its condition clears. The two directions share no state, so traffic in one direction never holds up the other.

Top module: `cond_xchg_top`

## Requirements
- R1: After reset both mailboxes are vacant (full low, vacant high) and both stored flags read 0; with no strobe asserted, neither stall output is high.
- R2: A load that completes stores the presented data bit. From the next cycle the mailbox is full and not vacant.
- R3: A take that completes presents the stored flag on the mailbox's data output in the same cycle. From the next cycle the mailbox is vacant and not full, unless a load completes in the same cycle.
- R4: A take aimed at a vacant mailbox raises the taking processor's stall in that cycle and leaves the stored flag unchanged.
- R5: A load aimed at a full mailbox, with no take in the same cycle, raises the loading processor's stall in that cycle. The mailbox keeps its old value and stays full.
- R6: A strobe held through a stall completes in the first cycle its condition clears, and the stall drops in that same cycle.
- R7: A take and a load on a full mailbox in the same cycle both complete: the take sees the old flag, neither side stalls, and the mailbox stays full holding the new flag.
- R8: A take and a load on a vacant mailbox in the same cycle: the load completes and the take stalls. The take then completes in the next cycle with the new flag.
- R9: The two directions are independent. The status and flag of one mailbox change only through its own strobes. The bit-side stall is the OR of the transfer-full and probe-vacant conditions, and the byte-side stall is the OR of the fetch-vacant and post-full conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both processors |
| rst_n | input | 1 | Asynchronous active-low reset |
| bp_xfer | input | 1 | Bit side: load strobe for the bit-to-byte mailbox |
| bp_xfer_d | input | 1 | Bit side: condition bit to load |
| bp_probe | input | 1 | Bit side: take strobe for the byte-to-bit mailbox |
| bp_probe_q | output | 1 | Stored flag of the byte-to-bit mailbox |
| bp_stall | output | 1 | Bit processor must hold its strobe and wait |
| yp_fetch | input | 1 | Byte side: take strobe for the bit-to-byte mailbox |
| yp_fetch_q | output | 1 | Stored flag of the bit-to-byte mailbox |
| yp_post | input | 1 | Byte side: load strobe for the byte-to-bit mailbox |
| yp_post_d | input | 1 | Byte side: condition bit to load |
| yp_stall | output | 1 | Byte processor must hold its strobe and wait |
| b2y_full | output | 1 | Bit-to-byte mailbox holds an untaken value |
| b2y_vacant | output | 1 | Bit-to-byte mailbox has nothing to take |
| y2b_full | output | 1 | Byte-to-bit mailbox holds an untaken value |
| y2b_vacant | output | 1 | Byte-to-bit mailbox has nothing to take |

## Verification
The bench targets four risky cases: a take and a load on the same cycle, on a full mailbox and on a vacant one; a load into a full mailbox; and a take from a vacant one.

- If the same-cycle load is wrongly refused, the loading side stalls although room was made.
- If the same-cycle load is wrongly ordered after the clear, the mailbox ends vacant and the new flag is lost.
- If a blocked load overwrites the mailbox, the flag that is later taken has changed.
- If the stall is registered rather than combinational, a held strobe completes one cycle late.

Further vectors drive both directions at once and check that a stall in one direction does not disturb the status of the other.

// File: rtl/cond_xchg_pkg.sv
package cond_xchg_pkg;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_B2Y = 0;
  localparam int unsigned DIR_Y2B = 1;

  typedef struct packed {
    logic full;
    logic vacant;
  } mbox_stat_t;

  // a take completes only when there is something to take
  function automatic logic take_fires(input logic take, input logic full);
    return take & full;
  endfunction

  // a load completes into a vacant box, or into a full one being taken now
  function automatic logic load_fires(input logic load, input logic take,
                                      input logic full);
    return load & (~full | take_fires(take, full));
  endfunction

endpackage

// File: rtl/cond_mbox_cell.sv
module cond_mbox_cell
  import cond_xchg_pkg::*;
#(
  parameter int unsigned FLAG_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [FLAG_W-1:0] load_d,
  input  logic              take_req,
  output logic [FLAG_W-1:0] flag_q,
  output mbox_stat_t        stat,
  output logic              load_stall,
  output logic              take_stall
);

  logic              full_r;
  logic              vacant_r;
  logic [FLAG_W-1:0] flag_r;
  logic              take_go;
  logic              load_go;

  assign take_go    = take_fires(take_req, full_r);
  assign load_go    = load_fires(load_req, take_req, full_r);
  assign take_stall = take_req & ~take_go;
  assign load_stall = load_req & ~load_go;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_r   <= 1'b0;
      vacant_r <= 1'b1;
      flag_r   <= '0;
    end else if (load_go) begin
      full_r   <= 1'b1;
      vacant_r <= 1'b0;
      flag_r   <= load_d;
    end else if (take_go) begin
      full_r   <= 1'b0;
      vacant_r <= 1'b1;
    end
  end

  assign flag_q      = flag_r;
  assign stat.full   = full_r;
  assign stat.vacant = vacant_r;

  AST_STAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({full_r, vacant_r})); // R2
  AST_LOAD_STORES: assert property (@(posedge clk) disable iff (!rst_n)
    load_go |=> full_r && (flag_r == $past(load_d))); // R2
  AST_TAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    take_go && !load_go |=> vacant_r && !full_r); // R3
  AST_TAKE_VACANT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    take_req && vacant_r |-> take_stall); // R4
  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    load_stall |=> full_r && $stable(flag_r)); // R5
  AST_SAME_CYCLE_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    load_req && take_req && full_r |-> !load_stall && !take_stall); // R7
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req && !take_req |=> $stable(full_r) && $stable(flag_r)); // R9

endmodule

// File: rtl/cond_xchg_top.sv
module cond_xchg_top
  import cond_xchg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bp_xfer,
  input  logic bp_xfer_d,
  input  logic bp_probe,
  output logic bp_probe_q,
  output logic bp_stall,
  input  logic yp_fetch,
  output logic yp_fetch_q,
  input  logic yp_post,
  input  logic yp_post_d,
  output logic yp_stall,
  output logic b2y_full,
  output logic b2y_vacant,
  output logic y2b_full,
  output logic y2b_vacant
);

  logic [NUM_DIR-1:0] load_req;
  logic [NUM_DIR-1:0] load_d;
  logic [NUM_DIR-1:0] take_req;
  logic [NUM_DIR-1:0] flag_q;
  logic [NUM_DIR-1:0] load_stall;
  logic [NUM_DIR-1:0] take_stall;
  mbox_stat_t         stat [NUM_DIR];

  // bit-to-byte: bit side loads, byte side takes
  assign load_req[DIR_B2Y] = bp_xfer;
  assign load_d[DIR_B2Y]   = bp_xfer_d;
  assign take_req[DIR_B2Y] = yp_fetch;
  // byte-to-bit: byte side loads, bit side takes
  assign load_req[DIR_Y2B] = yp_post;
  assign load_d[DIR_Y2B]   = yp_post_d;
  assign take_req[DIR_Y2B] = bp_probe;

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_box
    cond_mbox_cell #(.FLAG_W(1)) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_req   (load_req[g]),
      .load_d     (load_d[g +: 1]),
      .take_req   (take_req[g]),
      .flag_q     (flag_q[g +: 1]),
      .stat       (stat[g]),
      .load_stall (load_stall[g]),
      .take_stall (take_stall[g])
    );
  end

  assign bp_stall   = load_stall[DIR_B2Y] | take_stall[DIR_Y2B];
  assign yp_stall   = take_stall[DIR_B2Y] | load_stall[DIR_Y2B];
  assign yp_fetch_q = flag_q[DIR_B2Y];
  assign bp_probe_q = flag_q[DIR_Y2B];
  assign b2y_full   = stat[DIR_B2Y].full;
  assign b2y_vacant = stat[DIR_B2Y].vacant;
  assign y2b_full   = stat[DIR_Y2B].full;
  assign y2b_vacant = stat[DIR_Y2B].vacant;

  AST_B2Y_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_xfer && !yp_fetch |=> $stable(b2y_full) && $stable(yp_fetch_q)); // R9
  AST_Y2B_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    !yp_post && !bp_probe |=> $stable(y2b_full) && $stable(bp_probe_q)); // R9
  AST_BP_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !bp_xfer && !bp_probe |-> !bp_stall); // R1
  AST_YP_IDLE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    !yp_fetch && !yp_post |-> !yp_stall); // R1

endmodule

// File: tb/tb_cond_xchg_top.sv
module tb_cond_xchg_top;

  logic clk = 1'b0;
  logic rst_n;
  logic bp_xfer, bp_xfer_d, bp_probe, yp_fetch, yp_post, yp_post_d;
  logic bp_probe_q, bp_stall, yp_fetch_q, yp_stall;
  logic b2y_full, b2y_vacant, y2b_full, y2b_vacant;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  cond_xchg_top dut (
    .clk(clk), .rst_n(rst_n),
    .bp_xfer(bp_xfer), .bp_xfer_d(bp_xfer_d), .bp_probe(bp_probe),
    .bp_probe_q(bp_probe_q), .bp_stall(bp_stall),
    .yp_fetch(yp_fetch), .yp_fetch_q(yp_fetch_q),
    .yp_post(yp_post), .yp_post_d(yp_post_d), .yp_stall(yp_stall),
    .b2y_full(b2y_full), .b2y_vacant(b2y_vacant),
    .y2b_full(y2b_full), .y2b_vacant(y2b_vacant)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // {xfer, xfer_d, fetch, post, post_d, probe |
  //  bp_stall, yp_stall, fetch_q, probe_q (before edge) | b2y_full, y2b_full (after edge)}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    12'b000000_0000_00, // idle
    12'b110000_0000_10, // R2 load 1
    12'b100000_1010_10, // R5 load into full blocked
    12'b001000_0010_00, // R3 take returns 1
    12'b001000_0110_00, // R4 take vacant
    12'b101000_0110_10, // R8 load 0 + take on vacant
    12'b111000_0000_10, // R7 take old 0, load 1
    12'b000111_1010_11, // R8 probe vacant, post 1
    12'b000001_0011_10, // R3 probe returns 1
    12'b000110_0011_11, // R2 post 1
    12'b000100_0111_11, // R5 post into full, R9 b2y untouched
    12'b100100_1111_11, // R9 both blocked
    12'b001001_0011_00  // R3 both taken
  };

  initial begin
    rst_n = 1'b0;
    {bp_xfer, bp_xfer_d, bp_probe, yp_fetch, yp_post, yp_post_d} = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 status", {4'b0, b2y_full, b2y_vacant, y2b_full, y2b_vacant}, 8'b0000_0101);
    chk("R1 flags/stalls", {4'b0, yp_fetch_q, bp_probe_q, bp_stall, yp_stall}, 8'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {bp_xfer, bp_xfer_d, yp_fetch, yp_post, yp_post_d, bp_probe} = VEC[i][11:6];
      #1;
      chk($sformatf("R9 stalls vec%0d", i), {6'b0, bp_stall, yp_stall}, {6'b0, VEC[i][5:4]});
      chk($sformatf("R3 flags vec%0d", i), {6'b0, yp_fetch_q, bp_probe_q}, {6'b0, VEC[i][3:2]});
      @(posedge clk);
      #1;
      chk($sformatf("R2 status vec%0d", i),
          {4'b0, b2y_full, b2y_vacant, y2b_full, y2b_vacant},
          {4'b0, VEC[i][1], ~VEC[i][1], VEC[i][0], ~VEC[i][0]});
    end

    // R6: probe held on vacant mailbox, post arrives later
    @(negedge clk);
    {bp_xfer, bp_xfer_d, yp_fetch, yp_post, yp_post_d, bp_probe} = 6'b000001;
    for (int k = 0; k < 3; k++) begin
      #1 chk("R6 waiting stall", {7'b0, bp_stall}, 8'd1);
      @(negedge clk);
    end
    yp_post = 1'b1; yp_post_d = 1'b0;
    #1 chk("R8 post lands while probe stalls", {6'b0, bp_stall, yp_stall}, 8'b10);
    @(negedge clk);
    yp_post = 1'b0;
    #1 chk("R6 stall drops, value seen", {6'b0, bp_stall, bp_probe_q}, 8'b00);
    chk("R6 still full before edge", {7'b0, y2b_full}, 8'd1);
    @(posedge clk); #1;
    chk("R6 taken after edge", {6'b0, y2b_full, y2b_vacant}, 8'b01);
    @(negedge clk);
    bp_probe = 1'b0;

    // R1: reset in mid operation clears a loaded mailbox
    bp_xfer = 1'b1; bp_xfer_d = 1'b1;
    @(negedge clk);
    bp_xfer = 1'b0;
    #1 chk("R2 loaded before reset", {6'b0, b2y_full, yp_fetch_q}, 8'b11);
    rst_n = 1'b0;
    #1 chk("R1 reset clears", {5'b0, b2y_full, b2y_vacant, yp_fetch_q}, 8'b010);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule